// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block scales a stereo sample stream by a gain that moves slowly between full level and silence, so that muting or unmuting a source makes no audible click. Each input frame arrives as a left and a right sample with a one-cycle strobe. One cycle later the scaled pair leaves with its own strobe. The gain is applied to both channels of the frame alike.

The gain is a step count `g` that runs from 0 (silence) to `RAMP_LEN` (unity). Each scaled sample equals `floor(sample * g / RAMP_LEN)`, computed with signed arithmetic. The mute request is looked at only on frame strobes. When it is high, `g` steps down by one per frame. When it is low, `g` steps up by one per frame. The count stops at both ends.

Because the direction is chosen again on every frame, a request that drops midway through a fade turns the ramp around at the level already reached. The return to unity then takes as many frames as the fade had used. A request raised again during a return turns the ramp around in the same way. With the default `RAMP_LEN` of 1024, a full fade in either direction takes 1024 frames.

Top module: `smute_ramp`

## Requirements
- R1: While `rst` is high on a clock edge, the gain returns to unity (count `RAMP_LEN`), `out_valid` goes low and both output samples go to zero.
- R2: With the gain at unity, each output sample equals its input sample exactly, including the most negative and most positive codes.
- R3: `out_valid` is high in the cycle after `in_valid` is high and low in the cycle after `in_valid` is low. Output samples hold their value between strobes.
- R4: A frame taken with `mute_req` high is scaled by the current count `g`. Afterwards the count is `g-1`, unless it is already 0.
- R5: After `RAMP_LEN` frames taken with `mute_req` high, starting from unity, every output sample is zero. It stays zero for as long as the request stays high.
- R6: A frame taken with `mute_req` low is scaled by the current count `g`. Afterwards the count is `g+1`, unless it is already `RAMP_LEN`. A steady low request holds unity.
- R7: If the request drops after `n` fading frames (`n < RAMP_LEN`), the output reaches unity again after exactly `n` further frames. If the request rises again during a return, the ramp reverses from the count reached.
- R8: Changes of `mute_req` in cycles without `in_valid` have no effect on the gain.
- R9: The left and right samples of a frame are scaled by the same count, so equal inputs give equal outputs.
- R10: Scaling rounds toward minus infinity. For example, input -1 at count 512 gives -1, and input 1 at count 512 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mute_req | input | 1 | Mute request, sampled on frame strobes |
| in_valid | input | 1 | Frame strobe for the input pair |
| in_left | input | SAMPLE_W | Left input sample, two's complement |
| in_right | input | SAMPLE_W | Right input sample, two's complement |
| out_valid | output | 1 | Frame strobe for the output pair |
| out_left | output | SAMPLE_W | Scaled left sample |
| out_right | output | SAMPLE_W | Scaled right sample |

## Verification
The hardest situations to reach are a reversal in the middle of a ramp and the exact frame on which the count returns to unity. The count is not a port, so the stimulus sends a probe sample of 2^20. For that input the output is the count times 1024, which makes the gain directly visible. The stimulus fades for a chosen number of frames, releases the request, and counts the frames until the probe comes back unscaled. Randomly timed toggles of the request between strobes, and during long random runs, then test the reversal from many different counts.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    function automatic ramp_dir_e pick_dir(input logic req);
        return req ? RAMP_DOWN : RAMP_UP;
    endfunction

    function automatic int unsigned gain_bits(input int unsigned ramp_len);
        return $clog2(ramp_len) + 1;
    endfunction

endpackage

// File: rtl/smr_gain_ctr.sv
module smr_gain_ctr
    import smr_pkg::*;
#(
    parameter int unsigned RAMP_LEN = 1024,
    localparam int unsigned GAIN_W  = gain_bits(RAMP_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              req,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(RAMP_LEN);

    ramp_dir_e dir;
    assign dir = pick_dir(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= TOP;
        end else if (step) begin
            unique case (dir)
                RAMP_DOWN: if (gain != '0) gain <= gain - 1'b1;
                RAMP_UP:   if (gain != TOP) gain <= gain + 1'b1;
                default:   gain <= gain;
            endcase
        end
    end
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned GAIN_W   = 11,
    localparam int unsigned SHIFT   = GAIN_W - 1,
    localparam int unsigned PW      = SAMPLE_W + GAIN_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SAMPLE_W-1:0] result
);
    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic [SAMPLE_W-1:0]  scaled;

    assign s_ext  = {{(PW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
    assign g_ext  = {{(PW-GAIN_W){1'b0}}, gain};
    assign prod   = s_ext * g_ext;
    assign scaled = SAMPLE_W'(prod >>> SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (load) begin
            result <= scaled;
        end
    end
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
    import smr_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RAMP_LEN = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mute_req,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    localparam int unsigned GAIN_W = gain_bits(RAMP_LEN);
    localparam int unsigned N_CH   = 2;

    logic [GAIN_W-1:0]   gain_q;
    logic [SAMPLE_W-1:0] ch_in  [N_CH];
    logic [SAMPLE_W-1:0] ch_out [N_CH];

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    smr_gain_ctr #(.RAMP_LEN(RAMP_LEN)) u_gain (
        .clk  (clk),
        .rst  (rst),
        .step (in_valid),
        .req  (mute_req),
        .gain (gain_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        smr_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
            .clk    (clk),
            .rst    (rst),
            .load   (in_valid),
            .sample (ch_in[c]),
            .gain   (gain_q),
            .result (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];
endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RAMP_LEN = 1024,
    parameter int unsigned GAIN_W   = 11
) (
    input logic                clk,
    input logic                rst,
    input logic                mute_req,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic [GAIN_W-1:0]   gain
);
    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(RAMP_LEN);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (gain == TOP && !out_valid && out_left == '0 && out_right == '0));

    // R2
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain == TOP) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R3
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R4
    fade_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mute_req && gain != '0) |=> gain == $past(gain) - 1'b1);

    // R5
    floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mute_req && gain == '0) |=> (gain == '0 && out_left == '0 && out_right == '0));

    // R6
    rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mute_req && gain != TOP) |=> gain == $past(gain) + 1'b1);

    // R6
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        gain <= TOP);

    // R8
    idle_gain_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(gain));

    // R9
    same_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_left == in_right) |=> out_left == out_right);
endmodule

bind smute_ramp smr_chk #(
    .SAMPLE_W (SAMPLE_W),
    .RAMP_LEN (RAMP_LEN),
    .GAIN_W   (GAIN_W)
) u_smr_chk (
    .clk       (clk),
    .rst       (rst),
    .mute_req  (mute_req),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .gain      (gain_q)
);

// File: tb/test_smute_ramp.sv
module test_smute_ramp;
    localparam int SW = 24;
    localparam int RL = 1024;
    localparam logic [SW-1:0] PROBE = SW'(1 << 20);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mute_req = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic          out_valid;
    logic [SW-1:0] out_left;
    logic [SW-1:0] out_right;

    int n_chk = 0;
    int n_bad = 0;
    int model_g = RL;
    bit done = 0;

    always #4 clk = ~clk;

    smute_ramp #(.SAMPLE_W(SW), .RAMP_LEN(RL)) i_smute_ramp (
        .clk(clk), .rst(rst), .mute_req(mute_req), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    function automatic longint expect_scaled(logic [SW-1:0] s, int g);
        longint sv = longint'($signed(s));
        longint p = sv * longint'(g);
        if (p >= 0) return p / RL;
        return -((-p + RL - 1) / RL);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(bit m, logic [SW-1:0] l, logic [SW-1:0] r, string req);
        longint el, er;
        @(negedge clk);
        mute_req = m; in_valid = 1'b1; in_left = l; in_right = r;
        el = expect_scaled(l, model_g);
        er = expect_scaled(r, model_g);
        if (m) begin if (model_g > 0) model_g--; end
        else   begin if (model_g < RL) model_g++; end
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " strobe"}, longint'(out_valid), 1);
        check({req, " left"}, longint'($signed(out_left)), el);
        check({req, " right"}, longint'($signed(out_right)), er);
    endtask

    // returns the count seen through the probe sample
    task automatic probe(bit m, output int g_seen);
        frame(m, PROBE, PROBE, "R7 probe");
        g_seen = int'($signed(out_left)) / 1024;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int g_seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 strobe", longint'(out_valid), 0);
        check("R1 left", longint'(out_left), 0);
        check("R1 right", longint'(out_right), 0);

        // R2: unity including extreme codes
        frame(1'b0, SW'(123456), SW'(-7), "R2 unity");
        frame(1'b0, {1'b1, {(SW-1){1'b0}}}, {1'b0, {(SW-1){1'b1}}}, "R2 extremes");
        check("R2 exact", longint'($signed(out_left)), -(longint'(1) << (SW-1)));
        // R3: strobe drops and data holds on an idle cycle
        @(negedge clk);
        check("R3 idle strobe", longint'(out_valid), 0);
        check("R3 hold", longint'($signed(out_right)), (longint'(1) << (SW-1)) - 1);

        // R4/R5: full fade then hold at silence
        for (int k = 0; k < RL; k++) frame(1'b1, SW'($urandom), SW'($urandom), "R4 fade");
        for (int k = 0; k < 8; k++) begin
            frame(1'b1, SW'($urandom), {1'b1, {(SW-1){1'b0}}}, "R5 silent");
            check("R5 zero", longint'(out_right), 0);
        end
        // R6: full rise then hold at unity
        for (int k = 0; k < RL + 8; k++) frame(1'b0, SW'($urandom), SW'($urandom), "R6 rise");

        // R7: reverse after 300 fading frames; count frames back to unity
        for (int k = 0; k < 300; k++) frame(1'b1, SW'($urandom), SW'($urandom), "R7 fade");
        begin
            int frames = 0;
            g_seen = 0;
            while (g_seen != RL && frames < RL + 4) begin
                probe(1'b0, g_seen);
                frames++;
            end
            check("R7 return frames", frames, 301);
        end
        // R7: rise again during a return
        for (int k = 0; k < 100; k++) frame(1'b1, PROBE, PROBE, "R7 down");
        for (int k = 0; k < 40; k++) frame(1'b0, PROBE, PROBE, "R7 up");
        probe(1'b1, g_seen);
        check("R7 second reversal count", g_seen, RL - 100 + 40);

        // R8: request toggles between strobes leave the count alone
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            mute_req = ~mute_req;
        end
        probe(1'b1, g_seen);
        check("R8 count unchanged", g_seen, RL - 100 + 40 - 1);

        // R10: rounding toward minus infinity at count 512
        while (model_g > 512) frame(1'b1, PROBE, PROBE, "R10 approach");
        frame(1'b1, SW'(-1), SW'(1), "R10 round");
        check("R10 neg", longint'($signed(out_left)), -1);
        check("R10 pos", longint'($signed(out_right)), 0);

        // R9 and random mix with gaps and toggles
        for (int k = 0; k < 3000; k++) begin
            logic [SW-1:0] a = SW'($urandom);
            if (($urandom % 64) == 0) mute_req = ~mute_req;
            if (($urandom % 8) == 0) begin
                @(negedge clk);
                mute_req = $urandom % 2;
            end
            if (($urandom % 4) == 0) frame(mute_req, a, a, "R9 equal pair");
            else frame(mute_req, a, SW'($urandom), "R4 R6 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule